// File: doc/BRIEF.md
# Machine-Mode Trap and Control Register Unit

This block owns the machine-level trap state of a single-hart core with two privilege levels, machine and user. The pipeline reports a synchronous exception with its cause code, the PC of the faulting instruction and a trap value. Three interrupt lines come in as levels: software, timer and external. When a trap is taken the block saves the PC, the cause and the trap value, and pushes the interrupt-enable and privilege state one level deep. It then issues a one-cycle redirect to the handler and raises the hart to machine mode.

The block also executes the return-from-trap and wait-for-interrupt instructions, and serves read, write, set-bit and clear-bit requests to its eight control registers. A control-register request uses a valid/ready handshake. The pipeline holds `csr_valid` and its fields steady until it sees `csr_ready` high in the same cycle. `csr_ready` drops while an exception is presented, while an interrupt is being taken, and while the hart sleeps after a wait-for-interrupt. A request that meets a low `csr_ready` is never applied. The pipeline presents at most one of a control-register request, a return or a wait-for-interrupt in a given cycle. Everything `pc_i` refers to is the instruction presented in that cycle.

Register addresses: status 0x300, interrupt enable 0x304, trap vector 0x305, scratch 0x340, exception PC 0x341, cause 0x342, trap value 0x343, interrupt pending 0x344. Request opcodes on `csr_op`: 0 read, 1 write, 2 set bits, 3 clear bits.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the hart is in machine mode (`priv_m`=1), `redirect_valid` and `sleeping` are 0, and the status, trap-vector and interrupt-enable registers read 0.
- R2: In machine mode an accepted request returns the register's value before the access on `csr_rdata` in the same cycle. It then applies write, set or clear. The status register holds the global enable in bit 3 and the saved enable in bit 7. It holds the saved privilege in bits 12:11, where a written nonzero value becomes 11 (machine) and 00 means user. The enable register keeps only bits 3, 7 and 11. The pending register shows the lines software, timer and external in bits 3, 7 and 11, and writes to it are ignored. Exception-PC bits 1:0 and trap-vector bit 1 read 0. Scratch, cause and trap value keep all 32 bits.
- R3: `csr_ready` is 0 while `exc_valid` is 1, while an interrupt is taken, and while `sleeping` is 1. A request not accepted leaves every register unchanged.
- R4: On any trap the saved enable takes the old global enable, the global enable clears, the saved privilege takes the privilege before the trap and `priv_m` becomes 1. The redirect is presented for one cycle, in the cycle after the trap.
- R5: On an exception the exception PC takes `pc_i`, the cause takes `exc_cause` with bit 31 clear, and the trap value takes `exc_tval`. On an interrupt bit 31 of the cause is set, the low bits hold the interrupt code and the trap value is 0.
- R6: Exceptions redirect to the trap-vector base (bits 31:2). Interrupts do the same when trap-vector bit 0 is 0, and go to the base plus 4 times the code when it is 1.
- R7: An interrupt is taken only if its enable bit is set and either the global enable is 1 or the hart is in user mode. Among those, external (code 11) wins over software (code 3), which wins over timer (code 7). A presented exception wins over any interrupt.
- R8: A return in machine mode redirects to the exception PC, copies the saved enable into the global enable, sets the saved enable to 1, moves to the saved privilege and sets the saved privilege to user.
- R9: A return or any control-register request in user mode, and a request to an unknown address in machine mode, trap as illegal instruction: cause 2, trap value 0, exception PC `pc_i`.
- R10: A wait-for-interrupt with no enabled interrupt pending sets `sleeping` from the next cycle until one is pending. If that interrupt may be taken, it traps with the exception PC set to the wait's PC plus 4. Otherwise the block redirects to the wait's PC plus 4 with no other state change. Disabled lines do not wake it. A wait issued while an enabled interrupt is already pending but not takeable redirects at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC of the instruction presented this cycle |
| exc_valid | input | 1 | Synchronous exception presented |
| exc_cause | input | 4 | Exception cause code |
| exc_tval | input | 32 | Exception trap value |
| irq_sw | input | 1 | Software interrupt line |
| irq_timer | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| mret_valid | input | 1 | Return-from-trap presented |
| wfi_valid | input | 1 | Wait-for-interrupt presented |
| csr_valid | input | 1 | Control-register request valid |
| csr_ready | output | 1 | Control-register request accepted this cycle |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write or mask operand |
| csr_rdata | output | 32 | Register value before the access |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| priv_m | output | 1 | 1 machine mode, 0 user mode |
| sleeping | output | 1 | Hart stalled in wait-for-interrupt |

## Verification
`csr_ready` and `csr_rdata` are combinational, so the bench drives each request just after a falling edge and samples them 1 ns later, within the same cycle. Everything else comes from registers: the redirect, `priv_m`, `sleeping` and every register update are due one rising edge after the stimulus. The bench therefore samples them at the next falling edge, and it reads stored registers back through later requests. Sweeps cover every exception code, every combination of the interrupt lines in both vector modes, and several patterns written to every register.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam logic [11:0] ADR_STATUS  = 12'h300;
  localparam logic [11:0] ADR_IEN     = 12'h304;
  localparam logic [11:0] ADR_VECTOR  = 12'h305;
  localparam logic [11:0] ADR_SCRATCH = 12'h340;
  localparam logic [11:0] ADR_EPC     = 12'h341;
  localparam logic [11:0] ADR_CAUSE   = 12'h342;
  localparam logic [11:0] ADR_TVAL    = 12'h343;
  localparam logic [11:0] ADR_IPEND   = 12'h344;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } reg_op_e;

  localparam int CODE_SOFT    = 3;
  localparam int CODE_TIMER   = 7;
  localparam int CODE_EXTERN  = 11;
  localparam int CODE_ILLEGAL = 2;

  localparam int BIT_GIE   = 3;
  localparam int BIT_SAVIE = 7;
  localparam int BIT_SPL   = 11;
  localparam int BIT_SPH   = 12;
  localparam int NUM_IRQ   = 3;
endpackage

// File: rtl/mtrap_irq_pick.sv
module mtrap_irq_pick
  import mtrap_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic [NUM_IRQ-1:0] pend,   // {external, timer, software}, already masked
  output logic               any,
  output logic [CAUSE_W-1:0] code
);
  always_comb begin
    any  = |pend;
    code = '0;
    if (pend[2])      code = CAUSE_W'(CODE_EXTERN);
    else if (pend[0]) code = CAUSE_W'(CODE_SOFT);
    else if (pend[1]) code = CAUSE_W'(CODE_TIMER);
  end
endmodule

// File: rtl/mtrap_vector.sv
module mtrap_vector #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic [XLEN-3:0]    base,
  input  logic               vec_mode,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] code,
  output logic [XLEN-1:0]    target
);
  logic [XLEN-1:0] offs;
  always_comb begin
    offs = '0;
    if (vec_mode && is_irq) offs = XLEN'(code) << 2;
    target = {base, 2'b00} + offs;
  end
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    exc_tval,
  input  logic               irq_sw,
  input  logic               irq_timer,
  input  logic               irq_ext,
  input  logic               mret_valid,
  input  logic               wfi_valid,
  input  logic               csr_valid,
  output logic               csr_ready,
  input  logic [1:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               priv_m,
  output logic               sleeping
);
  localparam int IRQ_BIT [NUM_IRQ] = '{CODE_SOFT, CODE_TIMER, CODE_EXTERN};

  // architectural state
  logic               st_mie, st_mpie, st_mpp_m, priv_q;
  logic [XLEN-3:0]    mtvec_base;
  logic               mtvec_vec;
  logic [XLEN-1:0]    mepc_q, mcause_q, mtval_q, mscratch_q;
  logic [NUM_IRQ-1:0] ien_q;
  logic               sleep_q;
  logic [XLEN-1:0]    resume_pc_q;
  logic               redir_v_q;
  logic [XLEN-1:0]    redir_pc_q;

  // interrupt selection
  logic [NUM_IRQ-1:0] lines, pend;
  logic               irq_any, irq_ok;
  logic [CAUSE_W-1:0] irq_code;

  assign lines = {irq_ext, irq_timer, irq_sw};
  assign pend  = lines & ien_q;

  mtrap_irq_pick #(.CAUSE_W(CAUSE_W)) u_pick (
    .pend (pend),
    .any  (irq_any),
    .code (irq_code)
  );

  assign irq_ok = irq_any && (st_mie || !priv_q);

  // arbitration of the cycle's events
  logic act, gate, take_exc_ext, take_irq, csr_fire, addr_ok, illegal;
  logic mret_do, wfi_do, wfi_sleep, resume, trap_go, csr_wen;

  assign act          = !sleep_q;
  assign take_exc_ext = act && exc_valid;
  assign take_irq     = !take_exc_ext && irq_ok;
  assign gate         = act && !exc_valid && !irq_ok;
  assign csr_ready    = gate;
  assign csr_fire     = csr_valid && gate;
  assign illegal      = (csr_fire && (!priv_q || !addr_ok)) ||
                        (gate && mret_valid && !priv_q);
  assign mret_do      = gate && mret_valid && priv_q;
  assign wfi_do       = gate && wfi_valid;
  assign wfi_sleep    = wfi_do && !irq_any;
  assign resume       = (sleep_q && irq_any && !irq_ok) || (wfi_do && irq_any);
  assign trap_go      = take_exc_ext || take_irq || illegal;
  assign csr_wen      = csr_fire && priv_q && addr_ok && (reg_op_e'(csr_op) != OP_READ);

  // register read and new-value computation
  logic [XLEN-1:0] ien_word, pend_word, nv;

  always_comb begin
    ien_word  = '0;
    pend_word = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      ien_word[IRQ_BIT[i]]  = ien_q[i];
      pend_word[IRQ_BIT[i]] = lines[i];
    end
  end

  always_comb begin
    csr_rdata = '0;
    addr_ok   = 1'b1;
    case (csr_addr)
      ADR_STATUS: begin
        csr_rdata[BIT_GIE]         = st_mie;
        csr_rdata[BIT_SAVIE]       = st_mpie;
        csr_rdata[BIT_SPH:BIT_SPL] = {2{st_mpp_m}};
      end
      ADR_IEN:     csr_rdata = ien_word;
      ADR_VECTOR:  csr_rdata = {mtvec_base, 1'b0, mtvec_vec};
      ADR_SCRATCH: csr_rdata = mscratch_q;
      ADR_EPC:     csr_rdata = mepc_q;
      ADR_CAUSE:   csr_rdata = mcause_q;
      ADR_TVAL:    csr_rdata = mtval_q;
      ADR_IPEND:   csr_rdata = pend_word;
      default:     addr_ok   = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_op_e'(csr_op))
      OP_SET:   nv = csr_rdata | csr_wdata;
      OP_CLEAR: nv = csr_rdata & ~csr_wdata;
      default:  nv = csr_wdata;
    endcase
  end

  // trap record
  logic [CAUSE_W-1:0] trap_code;
  logic [XLEN-1:0]    trap_epc, trap_cause, trap_tval, trap_target, step_pc;

  assign step_pc = pc_i + XLEN'(4);

  always_comb begin
    trap_code = CAUSE_W'(CODE_ILLEGAL);
    trap_tval = '0;
    trap_epc  = pc_i;
    if (take_exc_ext) begin
      trap_code = exc_cause;
      trap_tval = exc_tval;
    end else if (take_irq) begin
      trap_code = irq_code;
      if (sleep_q) trap_epc = resume_pc_q;
    end
    trap_cause                = '0;
    trap_cause[CAUSE_W-1:0]   = trap_code;
    trap_cause[XLEN-1]        = take_irq;
  end

  mtrap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .base     (mtvec_base),
    .vec_mode (mtvec_vec),
    .is_irq   (take_irq),
    .code     (trap_code),
    .target   (trap_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mie      <= 1'b0;
      st_mpie     <= 1'b0;
      st_mpp_m    <= 1'b0;
      priv_q      <= 1'b1;
      mtvec_base  <= '0;
      mtvec_vec   <= 1'b0;
      mepc_q      <= '0;
      mcause_q    <= '0;
      mtval_q     <= '0;
      mscratch_q  <= '0;
      ien_q       <= '0;
      sleep_q     <= 1'b0;
      resume_pc_q <= '0;
      redir_v_q   <= 1'b0;
      redir_pc_q  <= '0;
    end else begin
      redir_v_q <= 1'b0;
      if (trap_go) begin
        mepc_q     <= trap_epc;
        mcause_q   <= trap_cause;
        mtval_q    <= trap_tval;
        st_mpie    <= st_mie;
        st_mie     <= 1'b0;
        st_mpp_m   <= priv_q;
        priv_q     <= 1'b1;
        sleep_q    <= 1'b0;
        redir_v_q  <= 1'b1;
        redir_pc_q <= trap_target;
      end else if (mret_do) begin
        st_mie     <= st_mpie;
        st_mpie    <= 1'b1;
        priv_q     <= st_mpp_m;
        st_mpp_m   <= 1'b0;
        redir_v_q  <= 1'b1;
        redir_pc_q <= mepc_q;
      end else if (resume) begin
        sleep_q    <= 1'b0;
        redir_v_q  <= 1'b1;
        redir_pc_q <= sleep_q ? resume_pc_q : step_pc;
      end else if (wfi_sleep) begin
        sleep_q     <= 1'b1;
        resume_pc_q <= step_pc;
      end else if (csr_wen) begin
        case (csr_addr)
          ADR_STATUS: begin
            st_mie   <= nv[BIT_GIE];
            st_mpie  <= nv[BIT_SAVIE];
            st_mpp_m <= |nv[BIT_SPH:BIT_SPL];
          end
          ADR_IEN: begin
            for (int i = 0; i < NUM_IRQ; i++) ien_q[i] <= nv[IRQ_BIT[i]];
          end
          ADR_VECTOR: begin
            mtvec_base <= nv[XLEN-1:2];
            mtvec_vec  <= nv[0];
          end
          ADR_SCRATCH: mscratch_q <= nv;
          ADR_EPC:     mepc_q     <= {nv[XLEN-1:2], 2'b00};
          ADR_CAUSE:   mcause_q   <= nv;
          ADR_TVAL:    mtval_q    <= nv;
          default: ;
        endcase
      end
    end
  end

  assign redirect_valid = redir_v_q;
  assign redirect_pc    = redir_pc_q;
  assign priv_m         = priv_q;
  assign sleeping       = sleep_q;
endmodule

// File: rtl/mtrap_unit_sva.sv
module mtrap_unit_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_go,
  input logic            take_irq,
  input logic            take_exc_ext,
  input logic            mret_do,
  input logic            st_mie,
  input logic            st_mpie,
  input logic            priv_q,
  input logic [XLEN-1:0] mepc_q,
  input logic [XLEN-1:0] mcause_q,
  input logic [XLEN-3:0] mtvec_base,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            csr_ready,
  input logic            exc_valid,
  input logic            sleep_q,
  input logic            irq_any
);
  assert_trap_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> (priv_q && !st_mie && st_mpie == $past(st_mie) && redirect_valid));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> mcause_q[XLEN-1]);

  assert_exc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc_ext |=> !mcause_q[XLEN-1]);

  assert_exc_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc_ext |=> redirect_pc == {$past(mtvec_base), 2'b00});

  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mret_do |=> (redirect_valid && redirect_pc == $past(mepc_q) && st_mie == $past(st_mpie)));

  assert_busy_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !csr_ready);

  assert_busy_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> !csr_ready);

  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && !irq_any) |=> (sleep_q && !redirect_valid));
endmodule

bind mtrap_unit mtrap_unit_sva #(.XLEN(XLEN)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_go        (trap_go),
  .take_irq       (take_irq),
  .take_exc_ext   (take_exc_ext),
  .mret_do        (mret_do),
  .st_mie         (st_mie),
  .st_mpie        (st_mpie),
  .priv_q         (priv_q),
  .mepc_q         (mepc_q),
  .mcause_q       (mcause_q),
  .mtvec_base     (mtvec_base),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .csr_ready      (csr_ready),
  .exc_valid      (exc_valid),
  .sleep_q        (sleep_q),
  .irq_any        (irq_any)
);

// File: tb/mtrap_unit_tb.sv
module mtrap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_cause = '0;
  logic [31:0] exc_tval = '0;
  logic        irq_sw = 1'b0, irq_timer = 1'b0, irq_ext = 1'b0;
  logic        mret_valid = 1'b0, wfi_valid = 1'b0;
  logic        csr_valid = 1'b0;
  logic        csr_ready;
  logic [1:0]  csr_op = '0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        priv_m, sleeping;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  localparam logic [11:0] A_ST = 12'h300, A_IE = 12'h304, A_VEC = 12'h305, A_SCR = 12'h340,
                          A_EPC = 12'h341, A_CAU = 12'h342, A_TV = 12'h343, A_IP = 12'h344;

  always #4 clk = ~clk;  // 125 MHz

  mtrap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval),
    .irq_sw(irq_sw), .irq_timer(irq_timer), .irq_ext(irq_ext),
    .mret_valid(mret_valid), .wfi_valid(wfi_valid),
    .csr_valid(csr_valid), .csr_ready(csr_ready), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .priv_m(priv_m), .sleeping(sleeping)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_do(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd);
    csr_valid = 1'b1; csr_op = op; csr_addr = a; csr_wdata = wd;
    #1 rd = csr_rdata;
    @(negedge clk);
    csr_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] unused_rd;
    csr_do(2'd1, a, d, unused_rd);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_do(2'd0, a, 32'h0, d);
  endtask

  task automatic raise_exc(input logic [3:0] c, input logic [31:0] p, input logic [31:0] tv);
    exc_valid = 1'b1; exc_cause = c; pc_i = p; exc_tval = tv;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  task automatic do_mret(input logic [31:0] p);
    mret_valid = 1'b1; pc_i = p;
    @(negedge clk);
    mret_valid = 1'b0;
  endtask

  task automatic do_wfi(input logic [31:0] p);
    wfi_valid = 1'b1; pc_i = p;
    @(negedge clk);
    wfi_valid = 1'b0;
  endtask

  task automatic lines(input logic [2:0] v);  // {ext, timer, sw}
    irq_ext = v[2]; irq_timer = v[1]; irq_sw = v[0];
  endtask

  initial begin
    logic [31:0] v, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 priv", {31'b0, priv_m}, 32'd1);
    chk("R1 redirect", {31'b0, redirect_valid}, 32'd0);
    chk("R1 sleeping", {31'b0, sleeping}, 32'd0);
    rd(A_ST, r);  chk("R1 status", r, 32'h0);
    rd(A_VEC, r); chk("R1 vector", r, 32'h0);
    rd(A_IE, r);  chk("R1 enable", r, 32'h0);

    // R2 pattern sweep over every writable register
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0 : (k == 2) ? 32'hA5A5_5A5A : 32'h1234_5679;
      wr(A_SCR, v); rd(A_SCR, r); chk("R2 scratch", r, v);
      wr(A_TV, v);  rd(A_TV, r);  chk("R2 tval", r, v);
      wr(A_CAU, v); rd(A_CAU, r); chk("R2 cause", r, v);
      wr(A_EPC, v); rd(A_EPC, r); chk("R2 epc", r, v & ~32'h3);
      wr(A_VEC, v); rd(A_VEC, r); chk("R2 vector", r, v & ~32'h2);
      wr(A_IE, v);  rd(A_IE, r);  chk("R2 enable", r, v & 32'h888);
      wr(A_IE, 32'h0);
      wr(A_ST, v);  rd(A_ST, r);
      chk("R2 status", r, (v & 32'h88) | ((v[12:11] != 2'b00) ? 32'h1800 : 32'h0));
      wr(A_ST, 32'h0);
      wr(A_IP, v);  rd(A_IP, r);  chk("R2 pending write ignored", r, 32'h0);
    end
    wr(A_SCR, 32'hF0F0);
    csr_do(2'd2, A_SCR, 32'h000F, r); chk("R2 set old value", r, 32'hF0F0);
    csr_do(2'd3, A_SCR, 32'hF000, r); chk("R2 clear old value", r, 32'hF0FF);
    rd(A_SCR, r); chk("R2 set/clear result", r, 32'h00FF);
    for (int l = 0; l < 8; l++) begin
      lines(3'(l));
      rd(A_IP, r);
      chk("R2 pending lines", r, (32'(l & 1) << 3) | (32'((l >> 1) & 1) << 7) | (32'((l >> 2) & 1) << 11));
    end
    lines(3'b000);

    // R4 R5 R6 every exception code, vectored mode must not apply
    wr(A_VEC, 32'h101);
    for (int c = 0; c < 16; c++) begin
      wr(A_ST, 32'h8);
      raise_exc(4'(c), 32'h400 + 32'(c) * 4, 32'hDEAD_0000 + 32'(c));
      chk("R4 redirect strobe", {31'b0, redirect_valid}, 32'd1);
      chk("R6 exception target", redirect_pc, 32'h100);
      chk("R4 machine mode", {31'b0, priv_m}, 32'd1);
      rd(A_CAU, r); chk("R5 exception cause", r, 32'(c));
      rd(A_EPC, r); chk("R5 exception pc", r, 32'h400 + 32'(c) * 4);
      rd(A_TV, r);  chk("R5 exception tval", r, 32'hDEAD_0000 + 32'(c));
      rd(A_ST, r);  chk("R4 status stacked", r, 32'h1880);
    end

    // R7 R6 R8 every line combination in both vector modes
    for (int vm = 0; vm < 2; vm++) begin
      for (int l = 1; l < 8; l++) begin
        int code;
        code = ((l & 4) != 0) ? 11 : ((l & 1) != 0) ? 3 : 7;
        wr(A_VEC, 32'h200 | 32'(vm));
        wr(A_IE, 32'h888);
        wr(A_ST, 32'h8);
        lines(3'(l)); pc_i = 32'h3000;
        @(negedge clk);
        chk("R7 interrupt taken", {31'b0, redirect_valid}, 32'd1);
        chk("R6 interrupt target", redirect_pc, 32'h200 + ((vm != 0) ? 32'(code) * 4 : 32'h0));
        lines(3'b000);
        rd(A_CAU, r); chk("R7 priority code", r, 32'h8000_0000 | 32'(code));
        rd(A_TV, r);  chk("R5 interrupt tval", r, 32'h0);
        rd(A_ST, r);  chk("R4 status on interrupt", r, 32'h1880);
        do_mret(32'h10);
        chk("R8 return target", redirect_pc, 32'h3000);
        chk("R8 return strobe", {31'b0, redirect_valid}, 32'd1);
        rd(A_ST, r);  chk("R8 status after return", r, 32'h88);
      end
    end

    // R7 masking and global enable
    wr(A_ST, 32'h8); wr(A_IE, 32'h080);
    lines(3'b101);
    repeat (2) @(negedge clk);
    chk("R7 disabled lines ignored", {31'b0, redirect_valid}, 32'd0);
    lines(3'b111);
    @(negedge clk);
    chk("R7 enabled line taken", {31'b0, redirect_valid}, 32'd1);
    lines(3'b000);
    rd(A_CAU, r); chk("R7 masked priority", r, 32'h8000_0007);
    wr(A_ST, 32'h0); wr(A_IE, 32'h888);
    lines(3'b100);
    repeat (2) @(negedge clk);
    chk("R7 global enable clear in machine mode", {31'b0, redirect_valid}, 32'd0);
    lines(3'b000);

    // R8 drop to user, R7 user takes interrupt with global enable clear
    wr(A_VEC, 32'h201); wr(A_ST, 32'h0); wr(A_EPC, 32'h5000);
    do_mret(32'h10);
    chk("R8 return to user target", redirect_pc, 32'h5000);
    chk("R8 user mode", {31'b0, priv_m}, 32'd0);
    lines(3'b010); pc_i = 32'h5008;
    @(negedge clk);
    chk("R7 user interrupt taken", redirect_pc, 32'h21C);
    chk("R4 back to machine", {31'b0, priv_m}, 32'd1);
    lines(3'b000);
    rd(A_ST, r);  chk("R4 saved user privilege", r, 32'h0);
    rd(A_EPC, r); chk("R5 interrupted pc", r, 32'h5008);

    // R9 user register access and user return are illegal
    wr(A_EPC, 32'h6000);
    do_mret(32'h10);
    pc_i = 32'h6010;
    csr_do(2'd0, A_SCR, 32'h0, r);
    chk("R9 user access trap", redirect_pc, 32'h200);
    chk("R9 user access machine", {31'b0, priv_m}, 32'd1);
    rd(A_CAU, r); chk("R9 user access cause", r, 32'd2);
    rd(A_EPC, r); chk("R9 user access pc", r, 32'h6010);
    rd(A_TV, r);  chk("R9 user access tval", r, 32'h0);
    wr(A_EPC, 32'h6000);
    do_mret(32'h10);
    do_mret(32'h6020);
    chk("R9 user return trap", redirect_pc, 32'h200);
    rd(A_EPC, r); chk("R9 user return pc", r, 32'h6020);
    rd(A_CAU, r); chk("R9 user return cause", r, 32'd2);
    pc_i = 32'h6030;
    csr_do(2'd0, 12'h7C0, 32'h0, r);
    chk("R9 unknown address trap", {31'b0, redirect_valid}, 32'd1);
    rd(A_EPC, r); chk("R9 unknown address pc", r, 32'h6030);

    // R3 back-pressure and R7 exception beats interrupt
    wr(A_SCR, 32'h11);
    exc_valid = 1'b1; exc_cause = 4'd6; pc_i = 32'h6100; exc_tval = 32'h0;
    csr_valid = 1'b1; csr_op = 2'd1; csr_addr = A_SCR; csr_wdata = 32'h22;
    #1 chk("R3 ready low on exception", {31'b0, csr_ready}, 32'd0);
    @(negedge clk);
    exc_valid = 1'b0; csr_valid = 1'b0;
    rd(A_SCR, r); chk("R3 refused write ignored", r, 32'h11);
    wr(A_ST, 32'h8); wr(A_IE, 32'h888);
    lines(3'b001);
    raise_exc(4'd5, 32'h6200, 32'h0);
    chk("R7 exception wins target", redirect_pc, 32'h200);
    lines(3'b000);
    rd(A_CAU, r); chk("R7 exception wins cause", r, 32'd5);

    // R10 wait-for-interrupt
    wr(A_ST, 32'h0); wr(A_CAU, 32'h77);
    do_wfi(32'h7000);
    chk("R10 sleeping", {31'b0, sleeping}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 still sleeping", {31'b0, sleeping}, 32'd1);
    chk("R10 no redirect asleep", {31'b0, redirect_valid}, 32'd0);
    #1 chk("R3 ready low asleep", {31'b0, csr_ready}, 32'd0);
    lines(3'b001);
    @(negedge clk);
    chk("R10 resume strobe", {31'b0, redirect_valid}, 32'd1);
    chk("R10 resume target", redirect_pc, 32'h7004);
    chk("R10 awake", {31'b0, sleeping}, 32'd0);
    lines(3'b000);
    rd(A_CAU, r); chk("R10 no trap on resume", r, 32'h77);
    wr(A_ST, 32'h8);
    do_wfi(32'h7100);
    lines(3'b010);
    @(negedge clk);
    chk("R10 trap from sleep", redirect_pc, 32'h21C);
    lines(3'b000);
    rd(A_EPC, r); chk("R10 trap pc after wait", r, 32'h7104);
    rd(A_CAU, r); chk("R10 trap cause", r, 32'h8000_0007);
    wr(A_ST, 32'h0);
    lines(3'b100);
    do_wfi(32'h7200);
    chk("R10 immediate resume", redirect_pc, 32'h7204);
    chk("R10 immediate not sleeping", {31'b0, sleeping}, 32'd0);
    lines(3'b000);
    wr(A_IE, 32'h008);
    lines(3'b010);
    do_wfi(32'h7300);
    repeat (3) @(negedge clk);
    chk("R10 disabled line no wake", {31'b0, sleeping}, 32'd1);
    lines(3'b011);
    @(negedge clk);
    chk("R10 enabled line wakes", redirect_pc, 32'h7304);
    lines(3'b000);

    summary();
  end
endmodule